// File: doc/BRIEF.md
# Single-Bus Hardwired Control Step Sequencer

This block generates the per-step control signals for a CPU whose registers share one internal bus. A small step counter walks through a common three-step instruction fetch and then through the execute steps of the current opcode. In every step, the combinational decode of the counter, the opcode and the Z-register zero flag selects one bus driver and the registers that load from the bus. It also selects the ALU function and raises the memory read, memory write, wait-for-memory, PC-increment and flag-load strobes. An END strobe marks the last step of an instruction and sends the counter back to the first fetch step.

The datapath, the memory and the instruction decoder sit outside this block. The opcode input is expected to hold the decoded instruction from the fetch's last step until END. The memory-function-complete input is looked at only while the block requests a wait. Five instructions are sequenced: add an immediate to R1, swap R1 and R2, increment the memory word addressed by R1, compare R1 with R2, and a counted loop that uses R1 as its counter.

Top module: `bus_seq_ctrl`

## Requirements
- R1: Synchronous active-high reset puts the step number at 1. Encodings: `bus_out_en` bits are 0 PC, 1 R1, 2 R2, 3 MDR, 4 Z, 5 IR immediate, 6 IR offset. `reg_in_en` bits are 0 PC, 1 R1, 2 R2, 3 MAR, 4 MDR, 5 IR, 6 Y, 7 Z. `alu_op` codes are 0 none, 1 A+B, 2 A-B, 3 pass B, 4 B+1, 5 B-1.
- R2: The fetch runs in three steps for every opcode. Step 1 drives PC onto the bus into MAR, with read and PC increment. Step 2 asserts only the wait request. Step 3 drives MDR into IR.
- R3: While the wait request is high and memory-function-complete is low, the step number does not advance and, with the inputs steady, every output keeps its value.
- R4: Opcode 1 (add immediate) takes three execute steps. Step 4 moves R1 into Y. Step 5 drives the IR immediate with ALU A+B into Z. Step 6 moves Z into R1 with END.
- R5: Opcode 2 (swap) takes three execute steps. Step 4 drives R1 with ALU pass-B into Z. Step 5 moves R2 into R1. Step 6 moves Z into R2 with END. No program-visible register holds the temporary value.
- R6: Opcode 3 (memory increment) takes four execute steps. Step 4 moves R1 into MAR with read and wait. Step 5 drives MDR with ALU B+1 into Z. Step 6 moves Z into MDR with write and wait. Step 7 asserts END and nothing else. MAR is not loaded in steps 5 to 7.
- R7: Opcode 4 (compare) takes two execute steps. Step 4 moves R1 into Y. Step 5 drives R2 with ALU A-B, flag load and END, and loads no register.
- R8: Opcode 5 (loop) begins with step 4, which drives R1 with ALU B-1 into Z. Step 5 moves Z into R1, and END is raised in step 5 when `z_zero` is 1.
- R9: When `z_zero` is 0 in step 5 of opcode 5, the loop goes on. Step 6 moves PC into Y. Step 7 drives the IR offset with ALU A+B into Z. Step 8 moves Z into PC with END.
- R10: Any other opcode (0, 6, 7) asserts END in step 4, with no bus driver, no register load, no memory access and no flag load.
- R11: A step with END, unless it is stalled, is followed by step 1. A step without END, unless it is stalled, is followed by the next step number.
- R12: At most one bus driver is enabled at any time, and read and write are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | OPC_W | Decoded opcode of the current instruction |
| mfc | input | 1 | Memory function complete |
| z_zero | input | 1 | Z register holds zero |
| step_num | output | STEP_W | Current step number, 1 based |
| bus_out_en | output | 7 | One-hot bus driver enables |
| reg_in_en | output | 8 | Register load enables |
| alu_op | output | 3 | ALU function select |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| wait_mfc | output | 1 | Wait for memory completion |
| pc_inc | output | 1 | Increment PC |
| flags_ld | output | 1 | Load the flags register |
| end_step | output | 1 | Last step of the instruction |

## Verification
The assertions assume that `opcode` stays steady from step 3 until END, and that `z_zero` reflects the Z register by step 5 of a loop. They treat `mfc` as a qualifier of the wait request only. The vector walk holds each instruction's opcode for its whole fetch and execute span and keeps `mfc` high, so no stall happens there. The stall tests then lower `mfc` only in the steps that raise a wait request, and they keep the opcode fixed while the block is held.

// File: rtl/seq_ctl_pkg.sv
package seq_ctl_pkg;

  localparam int SRC_N = 7;
  localparam int DST_N = 8;

  // bus driver indices
  localparam int S_PC  = 0;
  localparam int S_R1  = 1;
  localparam int S_R2  = 2;
  localparam int S_MDR = 3;
  localparam int S_Z   = 4;
  localparam int S_IMM = 5;
  localparam int S_OFS = 6;

  // bus load indices
  localparam int D_PC  = 0;
  localparam int D_R1  = 1;
  localparam int D_R2  = 2;
  localparam int D_MAR = 3;
  localparam int D_MDR = 4;
  localparam int D_IR  = 5;
  localparam int D_Y   = 6;
  localparam int D_Z   = 7;

  localparam logic [2:0] OPC_ADDI = 3'd1;
  localparam logic [2:0] OPC_XCHG = 3'd2;
  localparam logic [2:0] OPC_INCM = 3'd3;
  localparam logic [2:0] OPC_CMP  = 3'd4;
  localparam logic [2:0] OPC_LOOP = 3'd5;

  localparam int FETCH_LAST = 3;

  typedef enum logic [2:0] {
    ALU_NOP   = 3'd0,
    ALU_ADD   = 3'd1,
    ALU_SUB   = 3'd2,
    ALU_PASSB = 3'd3,
    ALU_INCB  = 3'd4,
    ALU_DECB  = 3'd5
  } alu_op_e;

  typedef struct packed {
    logic [SRC_N-1:0] src;
    logic [DST_N-1:0] dst;
    alu_op_e          alu;
    logic             rd;
    logic             wr;
    logic             wmfc;
    logic             pc_inc;
    logic             flags_ld;
    logic             fin;
  } ctl_t;

endpackage

// File: rtl/seq_step_counter.sv
module seq_step_counter #(
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              restart,
  output logic [STEP_W-1:0] step
);

  localparam logic [STEP_W-1:0] FIRST = STEP_W'(1);

  always_ff @(posedge clk) begin
    if (rst)          step <= FIRST;
    else if (hold)    step <= step;
    else if (restart) step <= FIRST;
    else              step <= step + STEP_W'(1);
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    hold |=> (step == $past(step))) else $error("stall moved step"); // R3

  AST_RESTART_T1: assert property (@(posedge clk) disable iff (rst)
    (restart && !hold) |=> (step == FIRST)) else $error("END did not restart"); // R11

  AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (!restart && !hold) |=> (step == $past(step) + STEP_W'(1))) else $error("step skipped"); // R11

  AST_STEP_NONZERO: assert property (@(posedge clk) disable iff (rst)
    step != '0) else $error("step zero"); // R1

endmodule

// File: rtl/seq_fetch_decode.sv
module seq_fetch_decode
  import seq_ctl_pkg::*;
#(
  parameter int STEP_W = 4
) (
  input  logic [STEP_W-1:0] step,
  output ctl_t              ctl
);

  always_comb begin
    ctl = '0;
    case (int'(step))
      1: begin
        ctl.src[S_PC]  = 1'b1;
        ctl.dst[D_MAR] = 1'b1;
        ctl.rd         = 1'b1;
        ctl.pc_inc     = 1'b1;
      end
      2: ctl.wmfc = 1'b1;
      3: begin
        ctl.src[S_MDR] = 1'b1;
        ctl.dst[D_IR]  = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/seq_exec_decode.sv
module seq_exec_decode
  import seq_ctl_pkg::*;
#(
  parameter int STEP_W = 4,
  parameter int OPC_W  = 3
) (
  input  logic [STEP_W-1:0] step,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              z_zero,
  output ctl_t              ctl
);

  always_comb begin
    ctl = '0;
    case (3'(opcode))
      OPC_ADDI: begin
        case (int'(step))
          4: begin ctl.src[S_R1] = 1'b1; ctl.dst[D_Y] = 1'b1; end
          5: begin ctl.src[S_IMM] = 1'b1; ctl.alu = ALU_ADD; ctl.dst[D_Z] = 1'b1; end
          6: begin ctl.src[S_Z] = 1'b1; ctl.dst[D_R1] = 1'b1; ctl.fin = 1'b1; end
          default: ctl.fin = 1'b1;
        endcase
      end
      OPC_XCHG: begin
        case (int'(step))
          4: begin ctl.src[S_R1] = 1'b1; ctl.alu = ALU_PASSB; ctl.dst[D_Z] = 1'b1; end
          5: begin ctl.src[S_R2] = 1'b1; ctl.dst[D_R1] = 1'b1; end
          6: begin ctl.src[S_Z] = 1'b1; ctl.dst[D_R2] = 1'b1; ctl.fin = 1'b1; end
          default: ctl.fin = 1'b1;
        endcase
      end
      OPC_INCM: begin
        case (int'(step))
          4: begin
            ctl.src[S_R1] = 1'b1; ctl.dst[D_MAR] = 1'b1;
            ctl.rd = 1'b1; ctl.wmfc = 1'b1;
          end
          5: begin ctl.src[S_MDR] = 1'b1; ctl.alu = ALU_INCB; ctl.dst[D_Z] = 1'b1; end
          6: begin
            ctl.src[S_Z] = 1'b1; ctl.dst[D_MDR] = 1'b1;
            ctl.wr = 1'b1; ctl.wmfc = 1'b1;
          end
          default: ctl.fin = 1'b1;
        endcase
      end
      OPC_CMP: begin
        case (int'(step))
          4: begin ctl.src[S_R1] = 1'b1; ctl.dst[D_Y] = 1'b1; end
          default: begin
            ctl.src[S_R2] = 1'b1; ctl.alu = ALU_SUB;
            ctl.flags_ld = 1'b1; ctl.fin = 1'b1;
          end
        endcase
      end
      OPC_LOOP: begin
        case (int'(step))
          4: begin ctl.src[S_R1] = 1'b1; ctl.alu = ALU_DECB; ctl.dst[D_Z] = 1'b1; end
          5: begin ctl.src[S_Z] = 1'b1; ctl.dst[D_R1] = 1'b1; ctl.fin = z_zero; end
          6: begin ctl.src[S_PC] = 1'b1; ctl.dst[D_Y] = 1'b1; end
          7: begin ctl.src[S_OFS] = 1'b1; ctl.alu = ALU_ADD; ctl.dst[D_Z] = 1'b1; end
          default: begin ctl.src[S_Z] = 1'b1; ctl.dst[D_PC] = 1'b1; ctl.fin = 1'b1; end
        endcase
      end
      default: ctl.fin = 1'b1;
    endcase
  end

endmodule

// File: rtl/bus_seq_ctrl.sv
module bus_seq_ctrl
  import seq_ctl_pkg::*;
#(
  parameter int OPC_W  = 3,
  parameter int STEP_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [OPC_W-1:0]       opcode,
  input  logic                   mfc,
  input  logic                   z_zero,
  output logic [STEP_W-1:0]      step_num,
  output logic [SRC_N-1:0]       bus_out_en,
  output logic [DST_N-1:0]       reg_in_en,
  output logic [2:0]             alu_op,
  output logic                   mem_rd,
  output logic                   mem_wr,
  output logic                   wait_mfc,
  output logic                   pc_inc,
  output logic                   flags_ld,
  output logic                   end_step
);

  localparam logic [STEP_W-1:0] LAST_FETCH = STEP_W'(FETCH_LAST);

  logic [STEP_W-1:0] step;
  ctl_t              f_ctl;
  ctl_t              x_ctl;
  ctl_t              ctl;
  logic              stall;

  seq_step_counter #(.STEP_W(STEP_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .hold    (stall),
    .restart (ctl.fin),
    .step    (step)
  );

  seq_fetch_decode #(.STEP_W(STEP_W)) u_fetch (
    .step (step),
    .ctl  (f_ctl)
  );

  seq_exec_decode #(.STEP_W(STEP_W), .OPC_W(OPC_W)) u_exec (
    .step   (step),
    .opcode (opcode),
    .z_zero (z_zero),
    .ctl    (x_ctl)
  );

  assign ctl   = (step <= LAST_FETCH) ? f_ctl : x_ctl;
  assign stall = ctl.wmfc && !mfc;

  assign step_num   = step;
  assign bus_out_en = ctl.src;
  assign reg_in_en  = ctl.dst;
  assign alu_op     = ctl.alu;
  assign mem_rd     = ctl.rd;
  assign mem_wr     = ctl.wr;
  assign wait_mfc   = ctl.wmfc;
  assign pc_inc     = ctl.pc_inc;
  assign flags_ld   = ctl.flags_ld;
  assign end_step   = ctl.fin;

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_out_en)) else $error("bus contention"); // R12

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)) else $error("read with write"); // R12

  AST_MAR_STEADY: assert property (@(posedge clk) disable iff (rst)
    (3'(opcode) == OPC_INCM && step >= STEP_W'(5) && step <= STEP_W'(7))
      |-> !reg_in_en[D_MAR]) else $error("MAR reloaded"); // R6

  AST_FETCH_NO_END: assert property (@(posedge clk) disable iff (rst)
    (step <= LAST_FETCH) |-> !end_step) else $error("END in fetch"); // R2

  AST_WAIT_STALL_OUT: assert property (@(posedge clk) disable iff (rst)
    (stall && $stable(opcode)) |=> (wait_mfc || $changed(opcode) || $changed(z_zero)))
    else $error("wait dropped during stall"); // R3

endmodule

// File: tb/bus_seq_ctrl_test.sv
module bus_seq_ctrl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] opcode = 3'd0;
  logic       mfc = 1'b1;
  logic       z_zero = 1'b0;
  logic [3:0] step_num;
  logic [6:0] bus_out_en;
  logic [7:0] reg_in_en;
  logic [2:0] alu_op;
  logic       mem_rd, mem_wr, wait_mfc, pc_inc, flags_ld, end_step;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bus_seq_ctrl uut (
    .clk(clk), .rst(rst), .opcode(opcode), .mfc(mfc), .z_zero(z_zero),
    .step_num(step_num), .bus_out_en(bus_out_en), .reg_in_en(reg_in_en),
    .alu_op(alu_op), .mem_rd(mem_rd), .mem_wr(mem_wr), .wait_mfc(wait_mfc),
    .pc_inc(pc_inc), .flags_ld(flags_ld), .end_step(end_step)
  );

  localparam logic [6:0] B_NO = 7'h00, B_PC = 7'h01, B_R1 = 7'h02, B_R2 = 7'h04,
                         B_MDR = 7'h08, B_Z = 7'h10, B_IMM = 7'h20, B_OFS = 7'h40;
  localparam logic [7:0] L_NO = 8'h00, L_PC = 8'h01, L_R1 = 8'h02, L_R2 = 8'h04,
                         L_MAR = 8'h08, L_MDR = 8'h10, L_IR = 8'h20, L_Y = 8'h40,
                         L_Z = 8'h80;
  localparam logic [2:0] A_NO = 3'd0, A_ADD = 3'd1, A_SUB = 3'd2, A_PB = 3'd3,
                         A_INC = 3'd4, A_DEC = 3'd5;
  // {rd, wr, wait, pc_inc, flags, end}
  localparam logic [5:0] C_NO = 6'b000000, C_RD = 6'b100000, C_WR = 6'b010000,
                         C_WT = 6'b001000, C_PI = 6'b000100, C_FL = 6'b000010,
                         C_END = 6'b000001;

  localparam int ROWS = 41;
  // {opcode, mfc, z_zero, req, step, bus, load, alu, ctl}
  localparam logic [36:0] VEC [ROWS] = '{
    // add immediate, first fetch right after reset (R1, R2, R4)
    {3'd1, 1'b1, 1'b0, 4'd1,  4'd1, B_PC,  L_MAR, A_NO,  C_RD | C_PI},
    {3'd1, 1'b1, 1'b0, 4'd2,  4'd2, B_NO,  L_NO,  A_NO,  C_WT},
    {3'd1, 1'b1, 1'b0, 4'd2,  4'd3, B_MDR, L_IR,  A_NO,  C_NO},
    {3'd1, 1'b1, 1'b0, 4'd4,  4'd4, B_R1,  L_Y,   A_NO,  C_NO},
    {3'd1, 1'b1, 1'b0, 4'd4,  4'd5, B_IMM, L_Z,   A_ADD, C_NO},
    {3'd1, 1'b1, 1'b0, 4'd4,  4'd6, B_Z,   L_R1,  A_NO,  C_END},
    // swap (R11 restart, R5)
    {3'd2, 1'b1, 1'b0, 4'd11, 4'd1, B_PC,  L_MAR, A_NO,  C_RD | C_PI},
    {3'd2, 1'b1, 1'b0, 4'd2,  4'd2, B_NO,  L_NO,  A_NO,  C_WT},
    {3'd2, 1'b1, 1'b0, 4'd2,  4'd3, B_MDR, L_IR,  A_NO,  C_NO},
    {3'd2, 1'b1, 1'b0, 4'd5,  4'd4, B_R1,  L_Z,   A_PB,  C_NO},
    {3'd2, 1'b1, 1'b0, 4'd5,  4'd5, B_R2,  L_R1,  A_NO,  C_NO},
    {3'd2, 1'b1, 1'b0, 4'd5,  4'd6, B_Z,   L_R2,  A_NO,  C_END},
    // memory increment (R6)
    {3'd3, 1'b1, 1'b0, 4'd11, 4'd1, B_PC,  L_MAR, A_NO,  C_RD | C_PI},
    {3'd3, 1'b1, 1'b0, 4'd2,  4'd2, B_NO,  L_NO,  A_NO,  C_WT},
    {3'd3, 1'b1, 1'b0, 4'd2,  4'd3, B_MDR, L_IR,  A_NO,  C_NO},
    {3'd3, 1'b1, 1'b0, 4'd6,  4'd4, B_R1,  L_MAR, A_NO,  C_RD | C_WT},
    {3'd3, 1'b1, 1'b0, 4'd6,  4'd5, B_MDR, L_Z,   A_INC, C_NO},
    {3'd3, 1'b1, 1'b0, 4'd6,  4'd6, B_Z,   L_MDR, A_NO,  C_WR | C_WT},
    {3'd3, 1'b1, 1'b0, 4'd6,  4'd7, B_NO,  L_NO,  A_NO,  C_END},
    // compare (R7)
    {3'd4, 1'b1, 1'b0, 4'd11, 4'd1, B_PC,  L_MAR, A_NO,  C_RD | C_PI},
    {3'd4, 1'b1, 1'b0, 4'd2,  4'd2, B_NO,  L_NO,  A_NO,  C_WT},
    {3'd4, 1'b1, 1'b0, 4'd2,  4'd3, B_MDR, L_IR,  A_NO,  C_NO},
    {3'd4, 1'b1, 1'b0, 4'd7,  4'd4, B_R1,  L_Y,   A_NO,  C_NO},
    {3'd4, 1'b1, 1'b0, 4'd7,  4'd5, B_R2,  L_NO,  A_SUB, C_FL | C_END},
    // loop, counter reaches zero (R8)
    {3'd5, 1'b1, 1'b1, 4'd11, 4'd1, B_PC,  L_MAR, A_NO,  C_RD | C_PI},
    {3'd5, 1'b1, 1'b1, 4'd2,  4'd2, B_NO,  L_NO,  A_NO,  C_WT},
    {3'd5, 1'b1, 1'b1, 4'd2,  4'd3, B_MDR, L_IR,  A_NO,  C_NO},
    {3'd5, 1'b1, 1'b1, 4'd8,  4'd4, B_R1,  L_Z,   A_DEC, C_NO},
    {3'd5, 1'b1, 1'b1, 4'd8,  4'd5, B_Z,   L_R1,  A_NO,  C_END},
    // loop, branch taken (R9)
    {3'd5, 1'b1, 1'b0, 4'd11, 4'd1, B_PC,  L_MAR, A_NO,  C_RD | C_PI},
    {3'd5, 1'b1, 1'b0, 4'd2,  4'd2, B_NO,  L_NO,  A_NO,  C_WT},
    {3'd5, 1'b1, 1'b0, 4'd2,  4'd3, B_MDR, L_IR,  A_NO,  C_NO},
    {3'd5, 1'b1, 1'b0, 4'd9,  4'd4, B_R1,  L_Z,   A_DEC, C_NO},
    {3'd5, 1'b1, 1'b0, 4'd9,  4'd5, B_Z,   L_R1,  A_NO,  C_NO},
    {3'd5, 1'b1, 1'b0, 4'd9,  4'd6, B_PC,  L_Y,   A_NO,  C_NO},
    {3'd5, 1'b1, 1'b0, 4'd9,  4'd7, B_OFS, L_Z,   A_ADD, C_NO},
    {3'd5, 1'b1, 1'b0, 4'd9,  4'd8, B_Z,   L_PC,  A_NO,  C_END},
    // unknown opcode (R10)
    {3'd6, 1'b1, 1'b0, 4'd11, 4'd1, B_PC,  L_MAR, A_NO,  C_RD | C_PI},
    {3'd6, 1'b1, 1'b0, 4'd2,  4'd2, B_NO,  L_NO,  A_NO,  C_WT},
    {3'd6, 1'b1, 1'b0, 4'd2,  4'd3, B_MDR, L_IR,  A_NO,  C_NO},
    {3'd6, 1'b1, 1'b0, 4'd10, 4'd4, B_NO,  L_NO,  A_NO,  C_END}
  };

  function automatic logic [27:0] observed();
    return {step_num, bus_out_en, reg_in_en, alu_op,
            mem_rd, mem_wr, wait_mfc, pc_inc, flags_ld, end_step};
  endfunction

  task automatic check(input string req, input logic [27:0] exp);
    logic [27:0] got;
    got = observed();
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s step=%0d got=%h expected=%h", req, step_num, got, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired got=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [27:0] t4_vec;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // vector walk, mfc kept high
    for (int i = 0; i < ROWS; i++) begin
      if (i != 0) @(negedge clk);
      opcode = VEC[i][36:34];
      mfc    = VEC[i][33];
      z_zero = VEC[i][32];
      #1;
      check($sformatf("R%0d", VEC[i][31:28]), VEC[i][27:0]);
    end

    // R3: stall during fetch wait
    @(negedge clk); opcode = 3'd3; mfc = 1'b1; #1;
    check("R11", {4'd1, B_PC, L_MAR, A_NO, C_RD | C_PI});
    @(negedge clk); mfc = 1'b0; #1;
    check("R3", {4'd2, B_NO, L_NO, A_NO, C_WT});
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check("R3", {4'd2, B_NO, L_NO, A_NO, C_WT});
    end
    mfc = 1'b1;
    @(negedge clk); #1;
    check("R3", {4'd3, B_MDR, L_IR, A_NO, C_NO});

    // R3: stall on the operand read, outputs steady
    @(negedge clk); mfc = 1'b0; #1;
    t4_vec = {4'd4, B_R1, L_MAR, A_NO, C_RD | C_WT};
    check("R6", t4_vec);
    @(negedge clk); #1;
    check("R3", t4_vec);
    @(negedge clk); #1;
    check("R3", t4_vec);
    mfc = 1'b1;
    @(negedge clk); #1;
    check("R6", {4'd5, B_MDR, L_Z, A_INC, C_NO});

    // R3: stall on the write step
    @(negedge clk); mfc = 1'b0; #1;
    check("R6", {4'd6, B_Z, L_MDR, A_NO, C_WR | C_WT});
    @(negedge clk); #1;
    check("R3", {4'd6, B_Z, L_MDR, A_NO, C_WR | C_WT});
    mfc = 1'b1;
    @(negedge clk); #1;
    check("R6", {4'd7, B_NO, L_NO, A_NO, C_END});

    // unknown opcode 0 and 7 (R10)
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); opcode = (k == 0) ? 3'd0 : 3'd7; #1;
      check("R11", {4'd1, B_PC, L_MAR, A_NO, C_RD | C_PI});
      @(negedge clk); @(negedge clk); @(negedge clk); #1;
      check("R10", {4'd4, B_NO, L_NO, A_NO, C_END});
    end

    // R1: reset in the middle of an instruction
    @(negedge clk); opcode = 3'd5; z_zero = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    check("R9", {4'd5, B_Z, L_R1, A_NO, C_NO});
    rst = 1'b1;
    @(negedge clk); #1;
    check("R1", {4'd1, B_PC, L_MAR, A_NO, C_RD | C_PI});
    @(negedge clk); #1;
    check("R1", {4'd1, B_PC, L_MAR, A_NO, C_RD | C_PI});
    rst = 1'b0;
    @(negedge clk); #1;
    check("R2", {4'd2, B_NO, L_NO, A_NO, C_WT});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule